// File: doc/BRIEF.md
# Rectangular Pixel-Array Transfer Engine

The engine moves a rectangular block of 16-bit pixels between a 32-bit host data port and a two-dimensional pixel array. The default array is 1024 columns by 512 rows. A command decoder loads two parameter words and pulses `start`. The first word gives the top-left corner. The second word gives the width and the height. `rd_dir` selects the direction.

In the host-to-array direction, each accepted host word becomes two pixel writes: the low half first, then the high half. In the array-to-host direction, the engine reads two pixels through the synchronous single-port memory and packs them into one word. It holds that word on the read port until the host takes it.

The corner coordinates wrap independently at the array's column and row counts. A size field of zero selects the full dimension. The transfer stops exactly after its last pixel, even when that pixel falls in the low half of a word. A cancel input from the display-command side aborts any transfer in progress.

Top module: `vxfer_engine`

## Requirements
- R1: Parameter word 0 gives the start column in bits [COLS_W-1:0] and the start row in bits [16+ROWS_W-1:16]. Parameter word 1 gives the width and the height in the same bit positions. Other bits are ignored.
- R2: A width field of zero means 2^COLS_W columns, and a height field of zero means 2^ROWS_W rows.
- R3: Within a data word, the pixel in bits [15:0] is transferred before the pixel in bits [31:16]. The host accepts one word at most every second cycle, and the high-half write lands in the cycle after the word is accepted.
- R4: The pixel at column offset c and row offset r uses column (X+c) mod 2^COLS_W and row (Y+r) mod 2^ROWS_W.
- R5: Pixels are visited in row-major order. After the last pixel of the last row, `busy` drops and no further memory access occurs.
- R6: If the pixel count is odd, the high half of the final host word is not written, and the high half of the final read word is zero.
- R7: For a read transfer, `data_ready` is 1 in the cycle after the accepted `start`. It stays 1 until the final word is taken (`rd_valid` and `rd_ready` both high), and it is 0 in the next cycle.
- R8: `cmd_reset` ends any transfer: `busy`, `data_ready`, `rd_valid` and `wr_ready` are 0 in the next cycle, and no memory write happens in the cycle `cmd_reset` is high or afterwards.
- R9: `mem_addr` equals row*2^COLS_W + column. There is at most one access per cycle, and read data is taken from `mem_rdata` one cycle after the address.
- R10: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_data` hold their values.
- R11: A `start` pulse that arrives while `busy` is high is ignored, and the running transfer completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_reset | input | 1 | Cancel any transfer in progress |
| start | input | 1 | Begin a transfer using param0/param1 (ignored while busy) |
| rd_dir | input | 1 | 1 = array to host, 0 = host to array; sampled with start |
| param0 | input | 32 | Start column and start row |
| param1 | input | 32 | Width and height (0 = full) |
| wr_data | input | 32 | Host data word, two pixels |
| wr_valid | input | 1 | Host data word valid |
| wr_ready | output | 1 | Engine accepts a host word |
| rd_data | output | 32 | Packed word for the host |
| rd_valid | output | 1 | rd_data holds a word |
| rd_ready | input | 1 | Host takes rd_data |
| data_ready | output | 1 | Status: a read transfer has words to deliver |
| busy | output | 1 | A transfer is active |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write when 1, read when 0 |
| mem_addr | output | COLS_W+ROWS_W | Pixel address, row*2^COLS_W + column |
| mem_wdata | output | 16 | Pixel written |
| mem_rdata | input | 16 | Pixel read, valid one cycle after the address |

## Verification
The assertions assume that `mem_rdata` returns the addressed pixel exactly one cycle after a read strobe. They also assume that the parameter words and `rd_dir` are valid in the cycle `start` is high, and that the host uses the valid/ready rules on both data ports.

The bench keeps within these assumptions. Its memory model has a one-cycle registered read. It changes every input only at the falling edge and raises `start` while busy only in the one scenario that tests R11. The sweep uses a 16x8 array, so every wrap, zero-size and odd-count case can be compared pixel by pixel against arithmetic expectations.

// File: rtl/vxfer_pkg.sv
package vxfer_pkg;
   localparam int PIX_W  = 16;
   localparam int WORD_W = 32;
   localparam int LANES  = WORD_W / PIX_W;
   localparam int Y_LSB  = 16;

   typedef enum logic [2:0] {
      ST_IDLE,   // no transfer
      ST_WLO,    // waiting for a host word, low half written on accept
      ST_WHI,    // writing the held high half
      ST_RLO,    // issuing read of the low pixel
      ST_RHI,    // capturing low pixel, issuing read of the high pixel
      ST_RCAP,   // capturing high pixel
      ST_RLAST,  // capturing a lone final low pixel, high half zero
      ST_ROUT    // word presented to host
   } xfer_state_e;
endpackage

// File: rtl/vxfer_walker.sv
module vxfer_walker #(
   parameter int COLS_W = 10,
   parameter int ROWS_W = 9,
   localparam int ADDR_W = COLS_W + ROWS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [31:0]       param0,
   input  logic [31:0]       param1,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic              last
);
   localparam logic [COLS_W-1:0] COL_ONE = 1;
   localparam logic [ROWS_W-1:0] ROW_ONE = 1;

   logic [COLS_W-1:0] x0, wlim, col;
   logic [ROWS_W-1:0] y0, hlim, row;
   logic [COLS_W-1:0] cur_x;
   logic [ROWS_W-1:0] cur_y;
   logic              unused_param_bits;

   assign unused_param_bits = ^{param0[31:vxfer_pkg::Y_LSB+ROWS_W], param0[vxfer_pkg::Y_LSB-1:COLS_W],
                                param1[31:vxfer_pkg::Y_LSB+ROWS_W], param1[vxfer_pkg::Y_LSB-1:COLS_W]};

   // size minus one in field width: a zero field wraps to the full extent minus one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x0 <= '0; y0 <= '0; wlim <= '0; hlim <= '0; col <= '0; row <= '0;
      end else if (load) begin
         x0   <= param0[COLS_W-1:0];
         y0   <= param0[vxfer_pkg::Y_LSB +: ROWS_W];
         wlim <= param1[COLS_W-1:0] - COL_ONE;
         hlim <= param1[vxfer_pkg::Y_LSB +: ROWS_W] - ROW_ONE;
         col  <= '0;
         row  <= '0;
      end else if (step) begin
         if (col == wlim) begin
            col <= '0;
            row <= row + ROW_ONE;
         end else begin
            col <= col + COL_ONE;
         end
      end
   end

   assign cur_x = x0 + col;
   assign cur_y = y0 + row;
   assign addr  = {cur_y, cur_x};
   assign last  = (col == wlim) && (row == hlim);
endmodule

// File: rtl/vxfer_rd_pack.sv
module vxfer_rd_pack #(
   parameter int LANE_W = 16,
   parameter int N_LANES = 2,
   localparam int SEL_W = (N_LANES > 1) ? $clog2(N_LANES) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cap_en,
   input  logic [SEL_W-1:0]          cap_sel,
   input  logic                      zero_above,
   input  logic [LANE_W-1:0]         din,
   output logic [N_LANES*LANE_W-1:0] word
);
   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      logic [LANE_W-1:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane_q <= '0;
         else if (cap_en) begin
            if (cap_sel == SEL_W'(g))
               lane_q <= din;
            else if (zero_above && (SEL_W'(g) > cap_sel))
               lane_q <= '0;
         end
      end
      assign word[g*LANE_W +: LANE_W] = lane_q;
   end
endmodule

// File: rtl/vxfer_engine.sv
module vxfer_engine #(
   parameter int COLS_W = 10,
   parameter int ROWS_W = 9,
   localparam int ADDR_W = COLS_W + ROWS_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cmd_reset,
   input  logic                      start,
   input  logic                      rd_dir,
   input  logic [31:0]               param0,
   input  logic [31:0]               param1,
   input  logic [31:0]               wr_data,
   input  logic                      wr_valid,
   output logic                      wr_ready,
   output logic [31:0]               rd_data,
   output logic                      rd_valid,
   input  logic                      rd_ready,
   output logic                      data_ready,
   output logic                      busy,
   output logic                      mem_en,
   output logic                      mem_we,
   output logic [ADDR_W-1:0]         mem_addr,
   output logic [vxfer_pkg::PIX_W-1:0] mem_wdata,
   input  logic [vxfer_pkg::PIX_W-1:0] mem_rdata
);
   import vxfer_pkg::*;

   if (COLS_W < 1 || COLS_W > 15) begin : g_bad_cols
      $error("vxfer_engine: COLS_W must lie in 1..15");
   end
   if (ROWS_W < 1 || ROWS_W > 15) begin : g_bad_rows
      $error("vxfer_engine: ROWS_W must lie in 1..15");
   end
   if (LANES != 2) begin : g_bad_lanes
      $error("vxfer_engine: word must carry exactly two pixels");
   end

   xfer_state_e      state_q, state_d;
   logic             fin_q, fin_d;
   logic [PIX_W-1:0] hold_hi_q;
   logic             start_ok, wr_acc, step, last;
   logic             cap_en, cap_sel, zero_above;

   assign start_ok = start && (state_q == ST_IDLE) && !cmd_reset;
   assign wr_ready = (state_q == ST_WLO);
   assign wr_acc   = wr_valid && wr_ready;

   vxfer_walker #(.COLS_W(COLS_W), .ROWS_W(ROWS_W)) u_walk (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (start_ok),
      .param0 (param0),
      .param1 (param1),
      .step   (step),
      .addr   (mem_addr),
      .last   (last)
   );

   vxfer_rd_pack #(.LANE_W(PIX_W), .N_LANES(LANES)) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_en     (cap_en),
      .cap_sel    (cap_sel),
      .zero_above (zero_above),
      .din        (mem_rdata),
      .word       (rd_data)
   );

   always_comb begin
      state_d    = state_q;
      fin_d      = fin_q;
      mem_en     = 1'b0;
      mem_we     = 1'b0;
      mem_wdata  = wr_data[PIX_W-1:0];
      step       = 1'b0;
      cap_en     = 1'b0;
      cap_sel    = 1'b0;
      zero_above = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_ok) begin
               state_d = rd_dir ? ST_RLO : ST_WLO;
               fin_d   = 1'b0;
            end
         end
         ST_WLO: begin
            if (wr_acc) begin
               mem_en  = 1'b1;
               mem_we  = 1'b1;
               step    = 1'b1;
               state_d = last ? ST_IDLE : ST_WHI;
            end
         end
         ST_WHI: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = hold_hi_q;
            step      = 1'b1;
            state_d   = last ? ST_IDLE : ST_WLO;
         end
         ST_RLO: begin
            mem_en  = 1'b1;
            step    = 1'b1;
            fin_d   = last;
            state_d = last ? ST_RLAST : ST_RHI;
         end
         ST_RHI: begin
            mem_en  = 1'b1;
            step    = 1'b1;
            cap_en  = 1'b1;
            fin_d   = last;
            state_d = ST_RCAP;
         end
         ST_RCAP: begin
            cap_en  = 1'b1;
            cap_sel = 1'b1;
            state_d = ST_ROUT;
         end
         ST_RLAST: begin
            cap_en     = 1'b1;
            zero_above = 1'b1;
            state_d    = ST_ROUT;
         end
         ST_ROUT: begin
            if (rd_ready) state_d = fin_q ? ST_IDLE : ST_RLO;
         end
         default: state_d = ST_IDLE;
      endcase
      if (cmd_reset) begin
         state_d = ST_IDLE;
         mem_en  = 1'b0;
         mem_we  = 1'b0;
         step    = 1'b0;
         cap_en  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         fin_q     <= 1'b0;
         hold_hi_q <= '0;
      end else begin
         state_q <= state_d;
         fin_q   <= fin_d;
         if (wr_acc) hold_hi_q <= wr_data[WORD_W-1:PIX_W];
      end
   end

   assign rd_valid   = (state_q == ST_ROUT);
   assign busy       = (state_q != ST_IDLE);
   assign data_ready = (state_q == ST_RLO) || (state_q == ST_RHI) || (state_q == ST_RCAP) ||
                       (state_q == ST_RLAST) || (state_q == ST_ROUT);
endmodule

// File: rtl/vxfer_engine_chk.sv
module vxfer_engine_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_reset,
   input logic        start,
   input logic        rd_dir,
   input logic        wr_valid,
   input logic        wr_ready,
   input logic [31:0] rd_data,
   input logic        rd_valid,
   input logic        rd_ready,
   input logic        data_ready,
   input logic        busy,
   input logic        mem_en,
   input logic        mem_we
);
   p_ready_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && rd_dir && !cmd_reset) |=> data_ready);

   p_ready_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(data_ready) |-> ($past(rd_valid && rd_ready) || $past(cmd_reset)));

   p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reset |=> (!busy && !data_ready && !rd_valid && !wr_ready));

   p_cancel_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reset |-> !(mem_en && mem_we));

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready && !cmd_reset) |=> (rd_valid && $stable(rd_data)));

   p_high_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we && !(wr_valid && wr_ready)) |-> $past(wr_valid && wr_ready));

   p_no_write_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      data_ready |-> !mem_we);

   p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_en);

   p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !cmd_reset && !data_ready) |=> !data_ready);
endmodule

bind vxfer_engine vxfer_engine_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_reset  (cmd_reset),
   .start      (start),
   .rd_dir     (rd_dir),
   .wr_valid   (wr_valid),
   .wr_ready   (wr_ready),
   .rd_data    (rd_data),
   .rd_valid   (rd_valid),
   .rd_ready   (rd_ready),
   .data_ready (data_ready),
   .busy       (busy),
   .mem_en     (mem_en),
   .mem_we     (mem_we)
);

// File: tb/tb_vxfer_engine.sv
module tb_vxfer_engine;
   localparam int CW = 4;
   localparam int RW = 3;
   localparam int NC = 1 << CW;
   localparam int NR = 1 << RW;
   localparam int NP = NC * NR;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_reset = 1'b0, start = 1'b0, rd_dir = 1'b0;
   logic [31:0] param0 = '0, param1 = '0, wr_data = '0;
   logic wr_valid = 1'b0, rd_ready = 1'b0;
   logic wr_ready, rd_valid, data_ready, busy, mem_en, mem_we;
   logic [31:0] rd_data;
   logic [CW+RW-1:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;

   logic [15:0] vmem [NP];
   logic [15:0] exp_mem [NP];
   logic fill_req = 1'b0;
   int   fill_seed = 0;
   int   checks = 0, failures = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   vxfer_engine #(.COLS_W(CW), .ROWS_W(RW)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .start(start), .rd_dir(rd_dir),
      .param0(param0), .param1(param1), .wr_data(wr_data), .wr_valid(wr_valid),
      .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
      .data_ready(data_ready), .busy(busy), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   function automatic logic [15:0] pat(int i, int seed);
      return 16'h8000 | 16'((i * 37 + seed * 11) & 32'h7fff);
   endfunction

   function automatic logic [15:0] wpix(int k, int seed);
      return 16'((seed * 256 + k) & 32'h7fff);
   endfunction

   function automatic int paddr(int x, int y, int wn, int k);
      return ((y + k / wn) % NR) * NC + ((x + k % wn) % NC);
   endfunction

   always @(posedge clk) begin
      if (fill_req) begin
         for (int i = 0; i < NP; i++) vmem[i] <= pat(i, fill_seed);
      end else if (mem_en) begin
         if (mem_we) vmem[mem_addr] <= mem_wdata;
         else        mem_rdata <= vmem[mem_addr];
      end
   end

   task automatic chk(bit ok, string req, string what, int act, int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic do_fill(int seed);
      @(negedge clk); fill_seed = seed; fill_req = 1'b1;
      @(negedge clk); fill_req = 1'b0;
      for (int i = 0; i < NP; i++) exp_mem[i] = pat(i, seed);
   endtask

   task automatic pulse_start(int x, int y, int w, int h, bit dir);
      @(negedge clk);
      param0 = 32'hFE00_0000 | (32'(y) << 16) | 32'(x) | 32'h0000_F000;
      param1 = (32'(h) << 16) | 32'(w);
      rd_dir = dir; start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic send_word(logic [31:0] w);
      @(negedge clk); wr_data = w; wr_valid = 1'b1;
      while (!wr_ready) @(negedge clk);
      @(negedge clk); wr_valid = 1'b0;
   endtask

   task automatic cmp_mem(string req, string what);
      int bad = 0, first = -1;
      for (int i = 0; i < NP; i++) if (vmem[i] !== exp_mem[i]) begin
         bad++; if (first < 0) first = i;
      end
      if (bad == 0) chk(1'b1, req, what, 0, 0);
      else chk(1'b0, req, $sformatf("%s addr=%0d", what, first), vmem[first], exp_mem[first]);
   endtask

   task automatic run_write(int x, int y, int w, int h, int seed);
      int wn = (w == 0) ? NC : w;
      int hn = (h == 0) ? NR : h;
      int cnt = wn * hn;
      do_fill(seed);
      for (int k = 0; k < cnt; k++) exp_mem[paddr(x, y, wn, k)] = wpix(k, seed + 1);
      pulse_start(x, y, w, h, 1'b0);
      for (int j = 0; j < (cnt + 1) / 2; j++)
         send_word({wpix(2 * j + 1, seed + 1), wpix(2 * j, seed + 1)});
      @(negedge clk);
      chk(!busy, "R5", "busy after final write", busy, 0);
      cmp_mem("R1 R2 R3 R4 R6", $sformatf("write rect x=%0d y=%0d w=%0d h=%0d", x, y, w, h));
   endtask

   task automatic run_read(int x, int y, int w, int h, int seed, bit bp);
      int wn = (w == 0) ? NC : w;
      int hn = (h == 0) ? NR : h;
      int cnt = wn * hn;
      int words = (cnt + 1) / 2;
      int got = 0, cyc = 0;
      bit held = 1'b0;
      logic [31:0] held_v = '0, expw;
      do_fill(seed);
      pulse_start(x, y, w, h, 1'b1);
      chk(data_ready, "R7", "data_ready after read start", data_ready, 1);
      while (got < words) begin
         @(negedge clk);
         if (held) chk(rd_valid && rd_data == held_v, "R10", "word held under backpressure", rd_data, held_v);
         rd_ready = bp ? cyc[0] : 1'b1;
         cyc++;
         held = rd_valid && !rd_ready;
         held_v = rd_data;
         if (rd_valid && rd_ready) begin
            expw[15:0]  = pat(paddr(x, y, wn, 2 * got), seed);
            expw[31:16] = (2 * got + 1 < cnt) ? pat(paddr(x, y, wn, 2 * got + 1), seed) : 16'h0;
            chk(rd_data == expw, "R1 R4 R6 R9", $sformatf("read word %0d of rect x=%0d y=%0d w=%0d h=%0d",
                got, x, y, w, h), rd_data, expw);
            got++;
         end
      end
      @(negedge clk); rd_ready = 1'b0;
      chk(!data_ready && !busy, "R7", "data_ready cleared after final word", data_ready, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int wx[10] = '{0, 3, 14, 0, 5, 2, 9, 15, 7, 11};
      int wy[10] = '{0, 2, 6, 0, 1, 3, 7, 5, 4, 0};
      int ww[10] = '{1, 5, 4, 0, 0, 2, 7, 1, 3, 16};
      int wh[10] = '{1, 3, 3, 0, 1, 0, 2, 8, 5, 1};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !data_ready && !rd_valid && !wr_ready && !mem_en, "R5", "reset state", busy, 0);

      for (int i = 0; i < 10; i++) begin
         run_write(wx[i], wy[i], ww[i] & 15, wh[i] & 7, i + 1);
         run_read(wx[i], wy[i], ww[i] & 15, wh[i] & 7, i + 20, i[0]);
      end

      // R8: cancel a write after one word
      do_fill(40);
      exp_mem[0] = 16'h1111; exp_mem[1] = 16'h2222;
      pulse_start(0, 0, 4, 2, 1'b0);
      send_word(32'h2222_1111);
      @(negedge clk); cmd_reset = 1'b1;
      @(negedge clk); cmd_reset = 1'b0;
      chk(!busy && !wr_ready, "R8", "write cancelled", busy, 0);
      wr_data = 32'h3333_3333; wr_valid = 1'b1;
      repeat (4) @(negedge clk);
      wr_valid = 1'b0;
      cmp_mem("R8", "no writes after cancel");

      // R8: cancel a read
      do_fill(41);
      pulse_start(2, 2, 6, 3, 1'b1);
      repeat (2) @(negedge clk);
      cmd_reset = 1'b1;
      @(negedge clk); cmd_reset = 1'b0;
      chk(!data_ready && !rd_valid && !busy, "R8", "read cancelled", data_ready, 0);

      // R11: start while busy is ignored
      do_fill(42);
      exp_mem[1 * NC + 1] = 16'h0A01; exp_mem[1 * NC + 2] = 16'h0A02; exp_mem[1 * NC + 3] = 16'h0A03;
      pulse_start(1, 1, 3, 1, 1'b0);
      send_word(32'h0A02_0A01);
      pulse_start(8, 4, 2, 2, 1'b1);
      chk(busy && !data_ready && wr_ready, "R11", "start ignored while busy", data_ready, 0);
      send_word(32'h7777_0A03);
      @(negedge clk);
      chk(!busy && !data_ready, "R11", "original transfer completed", busy, 0);
      cmp_mem("R11 R6", "only original rectangle written");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule